// File: doc/BRIEF.md
# Branch Record Trace Stack

The block sits next to a processor pipeline and keeps a short history of control transfers. Each taken branch, interrupt or exception shows up as one event carrying a source address, a target address and the current privilege level. While recording is enabled, the block pushes the source/target pair into a circular stack of `DEPTH` entries. A top-of-stack pointer always names the slot that holds the newest pair. Debug software reads the pointer and any entry through a plain index port.

A 32-bit control register holds the enables. It can be written only from privilege level 0 or in real-address mode. Recording switches itself off whenever a debug exception fires, so the history that led up to the exception stays frozen.

When trace messages are enabled, every event also raises a one-cycle message strobe one clock later, with the address pair attached. A second strobe requests a trace-store write. Two separate bits can suppress that request: one for privilege 0 and one for every nonzero privilege.

Top module: `lbr_trace_stack`

## Requirements
- R1: After reset, the control register reads 0, the pointer is 0, and neither strobe is high.
- R2: A control write takes effect on the next clock only when the writer's privilege is 0 or real-address mode is flagged. Any other write leaves the register unchanged.
- R3: Control bits 31 to 7 always read 0, whatever value is written.
- R4: The recording enable is control bit 0. While it is set, an event moves the pointer to (pointer + 1) mod DEPTH. The event's source and target addresses are then readable at that new index.
- R5: While control bit 0 is clear, events change neither the pointer nor any entry.
- R6: After DEPTH or more recorded events, the pointer wraps through 0 and each new pair overwrites the oldest entry.
- R7: A debug exception pulse clears control bit 0 on the next clock and leaves bits 6 to 1 unchanged.
- R8: An event in the same cycle as a debug exception is still recorded when bit 0 was set before that cycle. Bit 0 is cleared afterwards.
- R9: A control write in the same cycle as a debug exception stores the written bits, except that bit 0 ends up cleared.
- R10: The trace-message enable is control bit 2. While it is set, each event raises `msg_valid_o` for exactly one cycle on the following clock, with the event's addresses on `msg_from_o` and `msg_to_o`. This does not depend on bit 0. While bit 2 is clear, no message is raised.
- R11: `store_req_o` rises together with a message only when control bit 3 (trace store) is also set and the event is not suppressed. Bit 5 suppresses the request for privilege 0 events, and bit 6 suppresses it for nonzero privilege events.
- R12: Bits 1 (step on branches) and 4 (trace interrupt) are stored and read back as written, with no effect on recording.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Taken branch, interrupt or exception this cycle |
| evt_from_i | input | ADDR_W | Source address of the event |
| evt_to_i | input | ADDR_W | Target address of the event |
| evt_cpl_i | input | 2 | Privilege level of the event |
| dbg_exc_i | input | 1 | Debug exception pulse |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control write data |
| cfg_cpl_i | input | 2 | Privilege level of the writer |
| cfg_real_i | input | 1 | Writer is in real-address mode |
| cfg_rdata_o | output | 32 | Control register read value |
| tos_o | output | PTR_W | Top-of-stack pointer |
| rd_idx_i | input | PTR_W | Entry read index |
| rd_from_o | output | ADDR_W | Source address stored at rd_idx_i |
| rd_to_o | output | ADDR_W | Target address stored at rd_idx_i |
| msg_valid_o | output | 1 | Trace message strobe |
| msg_from_o | output | ADDR_W | Message source address |
| msg_to_o | output | ADDR_W | Message target address |
| store_req_o | output | 1 | Trace-store request strobe |

## Verification
The clashes of interest are a debug exception landing in the same cycle as a branch event, and a debug exception landing in the same cycle as a control write. The bench drives `dbg_exc_i` together with `evt_valid_i` while recording is on. The pair must still appear at the advanced pointer, and bit 0 must read 0 afterwards. The bench also drives the exception pulse together with a privileged write of `0x7F`, which must read back as `0x7E`. A behavioural model that applies the event first and the exception last judges every clock.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int unsigned CTRL_BITS = 7;

  typedef struct packed {
    logic off_usr;   // 6
    logic off_os;    // 5
    logic bt_int;    // 4
    logic bts;       // 3
    logic tr;        // 2
    logic step_br;   // 1
    logic rec_en;    // 0
  } ctrl_t;
endpackage

// File: rtl/lbr_ctrl_reg.sv
module lbr_ctrl_reg
  import lbr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic [1:0]  cpl_i,
  input  logic        real_i,
  input  logic        dbg_exc_i,
  output ctrl_t       ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  wr_ok;

  assign wr_ok = we_i && ((cpl_i == 2'd0) || real_i);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) ctrl_d = ctrl_t'(wdata_i[CTRL_BITS-1:0]);
    if (dbg_exc_i) ctrl_d.rec_en = 1'b0;  // exception wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/lbr_ring.sv
module lbr_ring #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned REC_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] from_i,
  input  logic [ADDR_W-1:0] to_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [PTR_W-1:0]  tos_o,
  output logic [ADDR_W-1:0] rd_from_o,
  output logic [ADDR_W-1:0] rd_to_o
);
  logic [PTR_W-1:0] tos_q, tos_nxt;
  logic [REC_W-1:0] rec_q [DEPTH];

  assign tos_nxt = tos_q + PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tos_q <= '0;
    else if (push_i) tos_q <= tos_nxt;
  end

  // contents carry no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (push_i && (tos_nxt == PTR_W'(g))) rec_q[g] <= {from_i, to_i};
    end
  end

  assign tos_o     = tos_q;
  assign rd_from_o = rec_q[rd_idx_i][REC_W-1:ADDR_W];
  assign rd_to_o   = rec_q[rd_idx_i][ADDR_W-1:0];
endmodule

// File: rtl/lbr_msg_out.sv
module lbr_msg_out
  import lbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [ADDR_W-1:0] from_i,
  input  logic [ADDR_W-1:0] to_i,
  input  logic [1:0]        cpl_i,
  input  ctrl_t             ctrl_i,
  output logic              msg_valid_o,
  output logic [ADDR_W-1:0] msg_from_o,
  output logic [ADDR_W-1:0] msg_to_o,
  output logic              store_req_o
);
  logic send, suppress;

  assign send     = evt_valid_i && ctrl_i.tr;
  assign suppress = (cpl_i == 2'd0) ? ctrl_i.off_os : ctrl_i.off_usr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      store_req_o <= 1'b0;
      msg_from_o  <= '0;
      msg_to_o    <= '0;
    end else begin
      msg_valid_o <= send;
      store_req_o <= send && ctrl_i.bts && !suppress;
      if (send) begin
        msg_from_o <= from_i;
        msg_to_o   <= to_i;
      end
    end
  end
endmodule

// File: rtl/lbr_trace_stack.sv
module lbr_trace_stack
  import lbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [ADDR_W-1:0] evt_from_i,
  input  logic [ADDR_W-1:0] evt_to_i,
  input  logic [1:0]        evt_cpl_i,
  input  logic              dbg_exc_i,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [1:0]        cfg_cpl_i,
  input  logic              cfg_real_i,
  output logic [31:0]       cfg_rdata_o,
  output logic [PTR_W-1:0]  tos_o,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_from_o,
  output logic [ADDR_W-1:0] rd_to_o,
  output logic              msg_valid_o,
  output logic [ADDR_W-1:0] msg_from_o,
  output logic [ADDR_W-1:0] msg_to_o,
  output logic              store_req_o
);
  ctrl_t ctrl;

  lbr_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .cpl_i     (cfg_cpl_i),
    .real_i    (cfg_real_i),
    .dbg_exc_i (dbg_exc_i),
    .ctrl_o    (ctrl)
  );

  lbr_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .push_i    (evt_valid_i && ctrl.rec_en),
    .from_i    (evt_from_i),
    .to_i      (evt_to_i),
    .rd_idx_i  (rd_idx_i),
    .tos_o     (tos_o),
    .rd_from_o (rd_from_o),
    .rd_to_o   (rd_to_o)
  );

  lbr_msg_out #(.ADDR_W(ADDR_W)) u_msg (
    .clk_i, .rst_ni,
    .evt_valid_i (evt_valid_i),
    .from_i      (evt_from_i),
    .to_i        (evt_to_i),
    .cpl_i       (evt_cpl_i),
    .ctrl_i      (ctrl),
    .msg_valid_o (msg_valid_o),
    .msg_from_o  (msg_from_o),
    .msg_to_o    (msg_to_o),
    .store_req_o (store_req_o)
  );

  assign cfg_rdata_o = {{(32 - CTRL_BITS){1'b0}}, ctrl};
endmodule

// File: rtl/lbr_trace_sva.sv
module lbr_trace_sva #(
  parameter int unsigned PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             dbg_exc_i,
  input logic             cfg_we_i,
  input logic [1:0]       cfg_cpl_i,
  input logic             cfg_real_i,
  input logic [31:0]      cfg_rdata_o,
  input logic [PTR_W-1:0] tos_o,
  input logic             msg_valid_o,
  input logic             store_req_o
);
  AST_TOS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && cfg_rdata_o[0] |=> tos_o == $past(tos_o) + PTR_W'(1)); // R4
  AST_TOS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_valid_i && cfg_rdata_o[0]) |=> $stable(tos_o)); // R5
  AST_DBG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_i |=> !cfg_rdata_o[0]); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[31:7] == '0); // R3
  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_cpl_i != 2'd0 && !cfg_real_i && !dbg_exc_i |=> $stable(cfg_rdata_o)); // R2
  AST_MSG_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && cfg_rdata_o[2] |=> msg_valid_o); // R10
  AST_MSG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_valid_i && cfg_rdata_o[2]) |=> !msg_valid_o); // R10
  AST_STORE_WITH_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> msg_valid_o); // R11
endmodule

bind lbr_trace_stack lbr_trace_sva #(.PTR_W(PTR_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .dbg_exc_i   (dbg_exc_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_cpl_i   (cfg_cpl_i),
  .cfg_real_i  (cfg_real_i),
  .cfg_rdata_o (cfg_rdata_o),
  .tos_o       (tos_o),
  .msg_valid_o (msg_valid_o),
  .store_req_o (store_req_o)
);

// File: tb/tb_lbr_trace_stack.sv
module tb_lbr_trace_stack;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_v = 1'b0, dbg = 1'b0, we = 1'b0, real_m = 1'b0;
  logic [AW-1:0] from_a = '0, to_a = '0;
  logic [1:0] ecpl = '0, wcpl = '0;
  logic [31:0] wdata = '0;
  logic [PW-1:0] rd_idx = '0;
  logic [31:0] rdata;
  logic [PW-1:0] tos;
  logic [AW-1:0] rd_from, rd_to, m_from_o, m_to_o;
  logic msg_v, st_req;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbr_trace_stack #(.ADDR_W(AW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_v), .evt_from_i(from_a), .evt_to_i(to_a), .evt_cpl_i(ecpl),
    .dbg_exc_i(dbg),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_cpl_i(wcpl), .cfg_real_i(real_m),
    .cfg_rdata_o(rdata), .tos_o(tos), .rd_idx_i(rd_idx),
    .rd_from_o(rd_from), .rd_to_o(rd_to),
    .msg_valid_o(msg_v), .msg_from_o(m_from_o), .msg_to_o(m_to_o),
    .store_req_o(st_req)
  );

  // reference model
  int unsigned m_ctrl, m_tos;
  logic [AW-1:0] m_f [DEPTH];
  logic [AW-1:0] m_t [DEPTH];
  bit m_ok [DEPTH];
  bit m_msg, m_st;
  logic [AW-1:0] m_mf, m_mt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_tos = 0; m_msg = 0; m_st = 0; m_mf = '0; m_mt = '0;
      for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;
    end else begin
      if (evt_v && m_ctrl[0]) begin
        m_tos = (m_tos + 1) % DEPTH;
        m_f[m_tos] = from_a; m_t[m_tos] = to_a; m_ok[m_tos] = 1;
      end
      m_msg = evt_v && m_ctrl[2];
      m_st  = m_msg && m_ctrl[3] && !((ecpl == 0) ? m_ctrl[5] : m_ctrl[6]);
      if (m_msg) begin m_mf = from_a; m_mt = to_a; end
      if (we && (wcpl == 0 || real_m)) m_ctrl = wdata & 32'h7f;
      if (dbg) m_ctrl[0] = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 R3 R7 R9 R12 ctrl", 64'(rdata), 64'(m_ctrl));
      chk("R4 R5 R6 tos", 64'(tos), 64'(m_tos));
      chk("R10 msg_valid", 64'(msg_v), 64'(m_msg));
      chk("R11 store_req", 64'(st_req), 64'(m_st));
      if (m_msg) chk("R10 msg payload", {m_from_o, m_to_o}, {m_mf, m_mt});
      if (m_ok[rd_idx]) chk("R4 R6 entry", {rd_from, rd_to}, {m_f[rd_idx], m_t[rd_idx]});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d, input logic [1:0] c, input bit rm, input bit ex);
    we = 1; wdata = d; wcpl = c; real_m = rm; dbg = ex;
    tick();
    we = 0; real_m = 0; dbg = 0; wcpl = 0;
  endtask

  task automatic ev(input logic [31:0] f, input logic [31:0] t, input logic [1:0] c, input bit ex);
    evt_v = 1; from_a = f; to_a = t; ecpl = c; dbg = ex;
    tick();
    evt_v = 0; dbg = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ctrl reset", 64'(rdata), 64'h0);
    chk("R1 tos reset", 64'(tos), 64'h0);
    chk("R1 strobes reset", 64'({msg_v, st_req}), 64'h0);
    rst_n = 1;
    tick();

    wr(32'h0000_0005, 2'd3, 0, 0);
    chk("R2 unprivileged write ignored", 64'(rdata), 64'h0);
    wr(32'hFFFF_FFFF, 2'd3, 1, 0);
    chk("R3 reserved bits zero, R2 real mode", 64'(rdata), 64'h7F);
    wr(32'h0000_0012, 2'd0, 0, 0);
    chk("R12 bits 1 and 4 kept", 64'(rdata), 64'h12);
    ev(32'h100, 32'h200, 2'd0, 0);
    chk("R5 disabled no push", 64'(tos), 64'h0);

    wr(32'h0000_0001, 2'd0, 0, 0);
    for (int i = 1; i <= 5; i++) ev(32'h1000 + i, 32'h2000 + i, 2'(i), 0);
    chk("R4 tos after five", 64'(tos), 64'd5);
    rd_idx = 5; #1;
    chk("R4 newest entry", {rd_from, rd_to}, {32'h1005, 32'h2005});

    for (int i = 0; i < DEPTH + 3; i++) begin
      rd_idx = PW'(i);
      ev(32'hA000 + i, 32'hB000 + i, 2'd3, 0);
    end
    chk("R6 wrapped tos", 64'(tos), 64'((5 + DEPTH + 3) % DEPTH));
    rd_idx = PW'((5 + DEPTH + 3) % DEPTH); #1;
    chk("R6 overwritten slot", {rd_from, rd_to}, {32'hA000 + DEPTH + 2, 32'hB000 + DEPTH + 2});

    wr(32'h0000_005F, 2'd0, 0, 0);
    ev(32'h0, 32'h0, 2'd0, 1);
    chk("R7 debug clears bit 0 only", 64'(rdata), 64'h5E);

    wr(32'h0000_0001, 2'd0, 0, 0);
    ev(32'hDEAD_0000, 32'hBEEF_0000, 2'd0, 1);
    rd_idx = tos; #1;
    chk("R8 event recorded", {rd_from, rd_to}, {32'hDEAD_0000, 32'hBEEF_0000});
    chk("R8 bit 0 cleared", 64'(rdata[0]), 64'h0);
    ev(32'h5, 32'h6, 2'd0, 0);
    chk("R8 frozen", {rd_from, rd_to}, {32'hDEAD_0000, 32'hBEEF_0000});

    wr(32'h0000_007F, 2'd0, 0, 1);
    chk("R9 write with debug", 64'(rdata), 64'h7E);

    wr(32'h0000_0004, 2'd0, 0, 0);
    ev(32'h3000, 32'h4000, 2'd2, 0);
    chk("R10 message", {32'(msg_v), m_from_o, m_to_o}, {32'h1, 32'h3000, 32'h4000});
    tick();
    chk("R10 single cycle", 64'(msg_v), 64'h0);
    wr(32'h0000_0000, 2'd0, 0, 0);
    ev(32'h3100, 32'h4100, 2'd0, 0);
    chk("R10 disabled", 64'(msg_v), 64'h0);

    wr(32'h0000_002C, 2'd0, 0, 0);
    ev(32'h1, 32'h2, 2'd0, 0);
    chk("R11 kernel suppressed", 64'(st_req), 64'h0);
    ev(32'h1, 32'h2, 2'd3, 0);
    chk("R11 user stored", 64'(st_req), 64'h1);
    wr(32'h0000_004C, 2'd0, 0, 0);
    ev(32'h1, 32'h2, 2'd1, 0);
    chk("R11 user suppressed", 64'(st_req), 64'h0);
    ev(32'h1, 32'h2, 2'd0, 0);
    chk("R11 kernel stored", 64'(st_req), 64'h1);
    wr(32'h0000_0004, 2'd0, 0, 0);
    ev(32'h1, 32'h2, 2'd0, 0);
    chk("R11 store bit off", 64'(st_req), 64'h0);

    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule